// File: doc/BRIEF.md
# Compressed Branch Target Decoder

This block rebuilds the target address of a traced branch from a stream of packet bytes. Each address byte gives seven payload bits, least significant group first, and its top bit says whether another address byte follows. A packet carries at most five address bytes. When a packet is shorter than that, the address bits it does not cover come from the previous branch target, which the block keeps in its own reference register. A full five-byte address can also switch the processor between three instruction-width states: word, halfword and byte. The raw value is then scaled to suit the state that applies.

After the address, a packet may carry up to three exception-information bytes. An escape bit in the address signals them, and the escape bit can be placed in one of two ways, picked by a mode input. The block splits the exception bytes into fields. When the last byte of a packet arrives, the block registers the target, the new state and the exception fields, and raises a one-cycle done pulse. The caller usually feeds the state output back into the current-state input. It loads the reference register whenever a full address becomes known by other means.

Top module: `branch_target_decoder`

## Requirements
- R1: Address byte k (k = 0..4) supplies raw bits [7k+6:7k] from its bits [6:0]. The address phase ends on a byte with bit 7 clear, or on the fifth byte whatever its bit 7 holds. The byte after that begins a new packet or the exception bytes.
- R2: For a packet with n < 5 address bytes, target bits at and above 7n are ORed with the reference register, and `state_o` takes `cur_state` (0 = word, 1 = halfword, 2 = byte).
- R3: For a five-byte packet whose fifth byte is b, checked in this priority: (b & 0xB8) == 0x08 gives word (0), (b & 0xB0) == 0x10 gives halfword (1), (b & 0xA0) == 0x20 gives byte (2). If none of these matches, `cur_state` is kept.
- R4: Scaling uses the resulting state. Word gives raw[30:1] followed by two zero bits. Halfword gives raw[31:1] followed by one zero bit. Byte gives raw[32:1].
- R5: With `alt_enc` = 1, a packet of two or more address bytes whose last address byte has bit 6 set carries exception bytes. Raw bit 7n-1 is cleared before scaling.
- R6: With `alt_enc` = 0, exception bytes follow only a five-byte address whose fifth byte has bit 6 set, and no address bit is cleared. A set bit 6 in a shorter packet has no effect.
- R7: Exception byte j supplies bits [7j+6:7j] of a value v. The exception phase ends on a byte with bit 7 clear or on the third byte. The fields are: non-secure = v[0], number = {v[15:11], v[4:1]}, cancel = v[5], alternate-ISA = v[6], hypervisor = v[12], resume = v[17:14].
- R8: With exactly two exception bytes and v[13] set, v is first rewritten as v[6:0] in bits [6:0] and v[13:7] in bits [20:14], with zeros elsewhere.
- R9: `done_o` is high for exactly the cycle after the final byte is accepted. The outputs hold until the next done. With no exception bytes, `exc_valid_o` is 0 and all exception fields are 0.
- R10: Every completed packet writes its target into the reference register. `ref_load` loads `ref_addr`, but a completion in the same cycle takes priority.
- R11: Reset clears every output, the reference register and any partly received packet.
- R12: `alt_enc` is sampled on the first byte of a packet and used for the whole packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte strobe |
| in_byte | input | 8 | Packet byte |
| ref_load | input | 1 | Load the reference register |
| ref_addr | input | 32 | Value for the reference register |
| cur_state | input | 2 | Current instruction-width state |
| alt_enc | input | 1 | 1 = alternative escape placement, 0 = original |
| done_o | output | 1 | Packet complete pulse |
| tgt_addr_o | output | 32 | Decoded branch target |
| state_o | output | 2 | Resulting state |
| exc_valid_o | output | 1 | Exception bytes were present |
| exc_ns_o | output | 1 | Non-secure flag |
| exc_num_o | output | 9 | Exception number |
| exc_cancel_o | output | 1 | Instruction cancelled |
| exc_altisa_o | output | 1 | Alternate ISA flag |
| exc_hyp_o | output | 1 | Hypervisor flag |
| exc_resume_o | output | 4 | Resume field |

## Verification
The assertions assume that `cur_state` and the reference register are stable on the cycle a packet completes. They also assume that state code 3 never occurs. The bench drives only codes 0 to 2, keeps `cur_state` fixed for the length of each packet, and raises `ref_load` only between packets. It also flips `alt_enc` after the first byte of some packets, so it deliberately breaks mode stability inside a packet to exercise R12. Bytes come from a seeded generator that follows the continuation rules, with idle gaps placed inside and between packets.

// File: rtl/brdec_pkg.sv
package brdec_pkg;
  typedef enum logic [1:0] {
    ST_WORD = 2'd0,
    ST_HALF = 2'd1,
    ST_BYTE = 2'd2
  } width_state_t;

  typedef struct packed {
    logic       ns;
    logic [8:0] num;
    logic       cancel;
    logic       alt_isa;
    logic       hyp;
    logic [3:0] resume;
  } exc_fields_t;
endpackage

// File: rtl/brdec_collect.sv
module brdec_collect #(
  parameter int MAX_ABYTES = 5,
  parameter int MAX_EBYTES = 3,
  parameter int CNT_W      = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic [7:0]                   in_byte,
  input  logic                         alt_enc,
  output logic                         fin,
  output logic                         mode_eff,
  output logic                         has_exc,
  output logic [CNT_W-1:0]             a_len,
  output logic [CNT_W-1:0]             e_len,
  output logic [MAX_ABYTES-1:0][7:0]   abuf_n,
  output logic [MAX_EBYTES-1:0][7:0]   ebuf_n
);
  typedef enum logic {PH_ADDR, PH_EXC} phase_t;

  phase_t                       phase_q;
  logic [CNT_W-1:0]             a_idx_q, e_idx_q, a_len_q;
  logic                         mode_q;
  logic [MAX_ABYTES-1:0][7:0]   abuf_q;
  logic [MAX_EBYTES-1:0][7:0]   ebuf_q;

  logic first, in_addr, in_exc, a_last, e_last, esc_flag;

  assign first    = (phase_q == PH_ADDR) && (a_idx_q == '0);
  assign mode_eff = first ? alt_enc : mode_q;
  assign in_addr  = in_valid && (phase_q == PH_ADDR);
  assign in_exc   = in_valid && (phase_q == PH_EXC);
  assign a_last   = in_addr && (!in_byte[7] || (int'(a_idx_q) == MAX_ABYTES-1));
  assign e_last   = in_exc  && (!in_byte[7] || (int'(e_idx_q) == MAX_EBYTES-1));

  always_comb begin
    if (mode_eff) esc_flag = (a_idx_q != '0) && in_byte[6];
    else          esc_flag = (int'(a_idx_q) == MAX_ABYTES-1) && in_byte[6];
  end

  assign fin     = (a_last && !esc_flag) || e_last;
  assign has_exc = (phase_q == PH_EXC);
  assign a_len   = in_addr ? a_idx_q + 1'b1 : a_len_q;
  assign e_len   = e_idx_q + 1'b1;

  for (genvar i = 0; i < MAX_ABYTES; i++) begin : g_abuf
    always_comb begin
      if (in_addr && (int'(a_idx_q) == i)) abuf_n[i] = in_byte;
      else if (first && in_valid)          abuf_n[i] = 8'h00;
      else                                 abuf_n[i] = abuf_q[i];
    end
  end

  for (genvar j = 0; j < MAX_EBYTES; j++) begin : g_ebuf
    always_comb begin
      if (in_exc && (int'(e_idx_q) == j)) ebuf_n[j] = in_byte;
      else if (first && in_valid)         ebuf_n[j] = 8'h00;
      else                                ebuf_n[j] = ebuf_q[j];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_ADDR;
      a_idx_q <= '0;
      e_idx_q <= '0;
      a_len_q <= '0;
      mode_q  <= 1'b0;
      abuf_q  <= '0;
      ebuf_q  <= '0;
    end else begin
      abuf_q <= abuf_n;
      ebuf_q <= ebuf_n;
      if (in_addr) begin
        mode_q <= mode_eff;
        if (a_last) begin
          a_len_q <= a_idx_q + 1'b1;
          a_idx_q <= '0;
          phase_q <= esc_flag ? PH_EXC : PH_ADDR;
        end else begin
          a_idx_q <= a_idx_q + 1'b1;
        end
      end
      if (in_exc) begin
        if (e_last) begin
          e_idx_q <= '0;
          phase_q <= PH_ADDR;
        end else begin
          e_idx_q <= e_idx_q + 1'b1;
        end
      end
    end
  end

  // R5 R6: the exception phase is only entered after an escape bit 6
  a_r5_exc_entry: assert property (@(posedge clk) disable iff (rst)
    $rose(phase_q == PH_EXC) |-> $past(in_valid && in_byte[6]));

  // R1: the address index never passes the last address slot
  a_r1_addr_cap: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_ADDR) |-> (int'(a_idx_q) < MAX_ABYTES));
endmodule

// File: rtl/brdec_addr.sv
module brdec_addr
  import brdec_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int MAX_ABYTES = 5,
  parameter int CNT_W      = 3
) (
  input  logic [MAX_ABYTES-1:0][7:0] abuf,
  input  logic [CNT_W-1:0]           a_len,
  input  logic                       alt_mode,
  input  logic                       has_exc,
  input  logic [ADDR_W-1:0]          ref_val,
  input  width_state_t               cur_st,
  output logic [ADDR_W-1:0]          tgt,
  output width_state_t               new_st
);
  localparam int RAW_W = 7 * MAX_ABYTES;

  logic [RAW_W-1:0]  raw;
  logic [ADDR_W-1:0] scaled, fill_mask;
  logic [7:0]        top_b;
  logic              five;

  always_comb begin
    raw = '0;
    for (int i = 0; i < MAX_ABYTES; i++) raw[7*i +: 7] = abuf[i][6:0];
    if (alt_mode && has_exc) begin
      for (int k = 0; k < RAW_W; k++)
        if (k == 7*int'(a_len) - 1) raw[k] = 1'b0;
    end
  end

  assign five  = (int'(a_len) == MAX_ABYTES);
  assign top_b = abuf[MAX_ABYTES-1];

  always_comb begin
    new_st = cur_st;
    if (five) begin
      if      ((top_b & 8'hB8) == 8'h08) new_st = ST_WORD;
      else if ((top_b & 8'hB0) == 8'h10) new_st = ST_HALF;
      else if ((top_b & 8'hA0) == 8'h20) new_st = ST_BYTE;
    end
  end

  always_comb begin
    case (new_st)
      ST_HALF: scaled = {raw[ADDR_W-1:1], 1'b0};
      ST_BYTE: scaled = raw[ADDR_W:1];
      default: scaled = {raw[ADDR_W-2:1], 2'b00};
    endcase
  end

  always_comb begin
    if (five) fill_mask = '0;
    else      fill_mask = {ADDR_W{1'b1}} << (7*int'(a_len));
  end

  assign tgt = scaled | (ref_val & fill_mask);
endmodule

// File: rtl/brdec_exc.sv
module brdec_exc
  import brdec_pkg::*;
#(
  parameter int MAX_EBYTES = 3,
  parameter int CNT_W      = 3
) (
  input  logic [MAX_EBYTES-1:0][7:0] ebuf,
  input  logic [CNT_W-1:0]           e_len,
  input  logic                       present,
  output exc_fields_t                fields
);
  localparam int EXC_W = 7 * MAX_EBYTES;

  logic [EXC_W-1:0] v, vf;

  always_comb begin
    v = '0;
    for (int j = 0; j < MAX_EBYTES; j++) v[7*j +: 7] = ebuf[j][6:0];
    vf = v;
    if ((int'(e_len) == 2) && v[13]) begin
      vf         = '0;
      vf[6:0]    = v[6:0];
      vf[14 +: 7] = v[13:7];
    end
  end

  always_comb begin
    fields = '0;
    if (present) begin
      fields.ns      = vf[0];
      fields.num     = {vf[15:11], vf[4:1]};
      fields.cancel  = vf[5];
      fields.alt_isa = vf[6];
      fields.hyp     = vf[12];
      fields.resume  = vf[17:14];
    end
  end
endmodule

// File: rtl/branch_target_decoder.sv
module branch_target_decoder
  import brdec_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int MAX_ABYTES = 5,
  parameter int MAX_EBYTES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  input  logic              ref_load,
  input  logic [ADDR_W-1:0] ref_addr,
  input  logic [1:0]        cur_state,
  input  logic              alt_enc,
  output logic              done_o,
  output logic [ADDR_W-1:0] tgt_addr_o,
  output logic [1:0]        state_o,
  output logic              exc_valid_o,
  output logic              exc_ns_o,
  output logic [8:0]        exc_num_o,
  output logic              exc_cancel_o,
  output logic              exc_altisa_o,
  output logic              exc_hyp_o,
  output logic [3:0]        exc_resume_o
);
  localparam int CNT_W = $clog2(MAX_ABYTES + MAX_EBYTES + 1);

  logic                       fin, mode_eff, has_exc;
  logic [CNT_W-1:0]           a_len, e_len;
  logic [MAX_ABYTES-1:0][7:0] abuf_n;
  logic [MAX_EBYTES-1:0][7:0] ebuf_n;
  logic [ADDR_W-1:0]          asm_tgt, ref_q;
  width_state_t               asm_st;
  exc_fields_t                exc_f, exc_q;
  logic [CNT_W-1:0]           len_q;
  logic                       alt_q;

  brdec_collect #(.MAX_ABYTES(MAX_ABYTES), .MAX_EBYTES(MAX_EBYTES), .CNT_W(CNT_W)) u_collect (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte), .alt_enc(alt_enc),
    .fin(fin), .mode_eff(mode_eff), .has_exc(has_exc), .a_len(a_len), .e_len(e_len),
    .abuf_n(abuf_n), .ebuf_n(ebuf_n)
  );

  brdec_addr #(.ADDR_W(ADDR_W), .MAX_ABYTES(MAX_ABYTES), .CNT_W(CNT_W)) u_addr (
    .abuf(abuf_n), .a_len(a_len), .alt_mode(mode_eff), .has_exc(has_exc),
    .ref_val(ref_q), .cur_st(width_state_t'(cur_state)), .tgt(asm_tgt), .new_st(asm_st)
  );

  brdec_exc #(.MAX_EBYTES(MAX_EBYTES), .CNT_W(CNT_W)) u_exc (
    .ebuf(ebuf_n), .e_len(e_len), .present(has_exc), .fields(exc_f)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o      <= 1'b0;
      tgt_addr_o  <= '0;
      state_o     <= ST_WORD;
      exc_valid_o <= 1'b0;
      exc_q       <= '0;
      ref_q       <= '0;
      len_q       <= '0;
      alt_q       <= 1'b0;
    end else begin
      done_o <= fin;
      if (fin) begin
        tgt_addr_o  <= asm_tgt;
        state_o     <= asm_st;
        exc_valid_o <= has_exc;
        exc_q       <= exc_f;
        ref_q       <= asm_tgt;
        len_q       <= a_len;
        alt_q       <= mode_eff;
      end else if (ref_load) begin
        ref_q <= ref_addr;
      end
    end
  end

  assign exc_ns_o     = exc_q.ns;
  assign exc_num_o    = exc_q.num;
  assign exc_cancel_o = exc_q.cancel;
  assign exc_altisa_o = exc_q.alt_isa;
  assign exc_hyp_o    = exc_q.hyp;
  assign exc_resume_o = exc_q.resume;

  // R9: a done pulse always follows an accepted byte
  a_r9_done_after_byte: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(in_valid));

  // R2: short packets keep the incoming state
  a_r2_state_inherited: assert property (@(posedge clk) disable iff (rst)
    (done_o && (int'(len_q) != MAX_ABYTES)) |-> (state_o == $past(cur_state)));

  // R2: reference bits above the covered range reach the target
  a_r2_upper_fill: assert property (@(posedge clk) disable iff (rst)
    (done_o && (int'(len_q) != MAX_ABYTES)) |->
      ((tgt_addr_o & $past(ref_q) & ({ADDR_W{1'b1}} << (7*int'(len_q))))
        == ($past(ref_q) & ({ADDR_W{1'b1}} << (7*int'(len_q))))));

  // R6: original placement never flags exceptions on short packets
  a_r6_orig_short_clean: assert property (@(posedge clk) disable iff (rst)
    (done_o && !alt_q && (int'(len_q) != MAX_ABYTES)) |-> !exc_valid_o);

  // R9: without exception bytes the fields read zero
  a_r9_fields_clear: assert property (@(posedge clk) disable iff (rst)
    (done_o && !exc_valid_o) |-> ({exc_ns_o, exc_num_o, exc_cancel_o,
      exc_altisa_o, exc_hyp_o, exc_resume_o} == '0));
endmodule

// File: tb/branch_target_decoder_test.sv
module branch_target_decoder_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        ref_load = 1'b0;
  logic [31:0] ref_addr = 32'h0;
  logic [1:0]  cur_state = 2'd0;
  logic        alt_enc = 1'b0;
  logic        done_o, exc_valid_o, exc_ns_o, exc_cancel_o, exc_altisa_o, exc_hyp_o;
  logic [31:0] tgt_addr_o;
  logic [1:0]  state_o;
  logic [8:0]  exc_num_o;
  logic [3:0]  exc_resume_o;

  branch_target_decoder uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .ref_load(ref_load), .ref_addr(ref_addr), .cur_state(cur_state), .alt_enc(alt_enc),
    .done_o(done_o), .tgt_addr_o(tgt_addr_o), .state_o(state_o), .exc_valid_o(exc_valid_o),
    .exc_ns_o(exc_ns_o), .exc_num_o(exc_num_o), .exc_cancel_o(exc_cancel_o),
    .exc_altisa_o(exc_altisa_o), .exc_hyp_o(exc_hyp_o), .exc_resume_o(exc_resume_o)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] addr;
    logic [1:0]  st;
    bit          hx;
    logic        ns, cancel, altisa, hyp;
    logic [8:0]  num;
    logic [3:0]  resume;
    bit          fix;
  } exp_t;

  logic [7:0]  pk_a[5];
  logic [7:0]  pk_e[3];
  int          pk_alen, pk_elen;
  bit          pk_alt;
  logic [31:0] mref = 32'h0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic bit esc_needed();
    if (pk_alt) return (pk_alen >= 2) && pk_a[pk_alen-1][6];
    return (pk_alen == 5) && pk_a[4][6];
  endfunction

  function automatic exp_t model();
    exp_t r;
    longint unsigned raw = 0, v = 0;
    r = '{default: 0};
    for (int i = 0; i < pk_alen; i++) raw |= longint'(pk_a[i] & 8'h7F) << (7*i);
    r.hx = esc_needed();
    if (pk_alt && r.hx) raw &= ~(64'd1 << (7*pk_alen - 1));
    r.st = cur_state;
    if (pk_alen == 5) begin
      if      ((pk_a[4] & 8'hB8) == 8'h08) r.st = 2'd0;
      else if ((pk_a[4] & 8'hB0) == 8'h10) r.st = 2'd1;
      else if ((pk_a[4] & 8'hA0) == 8'h20) r.st = 2'd2;
    end
    case (r.st)
      2'd1:    r.addr = 32'(raw & 64'hFFFFFFFE);
      2'd2:    r.addr = 32'((raw & 64'hFFFFFFFFE) >> 1);
      default: r.addr = 32'((raw & 64'hFFFFFFFE) << 1);
    endcase
    if (pk_alen < 5) r.addr |= mref & (32'hFFFFFFFF << (7*pk_alen));
    if (r.hx) begin
      for (int j = 0; j < pk_elen; j++) v |= longint'(pk_e[j] & 8'h7F) << (7*j);
      if (pk_elen == 2 && v[13]) begin
        v = (v & 64'h7F) | ((v & 64'h3F80) << 7);
        r.fix = 1;
      end
      r.ns = v[0]; r.cancel = v[5]; r.altisa = v[6]; r.hyp = v[12];
      r.num = {v[15:11], v[4:1]};
      r.resume = v[17:14];
    end
    return r;
  endfunction

  task automatic put_byte(input logic [7:0] b, input logic mode, input bit gap);
    if (gap) begin
      in_valid = 1'b0;
      @(negedge clk);
    end
    in_valid = 1'b1;
    in_byte  = b;
    alt_enc  = mode;
    @(negedge clk);
  endtask

  task automatic run_pkt(input string tag, input bit flip, input bit gaps, input bit idle_after);
    exp_t e;
    string ta;
    e = model();
    for (int i = 0; i < pk_alen; i++)
      put_byte(pk_a[i], (i > 0 && flip) ? ~pk_alt : pk_alt, gaps && (i > 0) && ($urandom % 3 == 0));
    if (e.hx)
      for (int j = 0; j < pk_elen; j++)
        put_byte(pk_e[j], flip ? ~pk_alt : pk_alt, gaps && ($urandom % 3 == 0));
    in_valid = 1'b0;
    ta = (pk_alen == 5) ? "R4" : "R2";
    chk(done_o === 1'b1, "R9", {tag, " done pulse"}, done_o, 1);
    chk(tgt_addr_o === e.addr, ta, {tag, " target"}, tgt_addr_o, e.addr);
    chk(state_o === e.st, (pk_alen == 5) ? "R3" : "R2", {tag, " state"}, state_o, e.st);
    chk(exc_valid_o === e.hx, pk_alt ? "R5" : "R6", {tag, " exc flag"}, exc_valid_o, e.hx);
    chk({exc_ns_o, exc_num_o, exc_cancel_o, exc_altisa_o, exc_hyp_o, exc_resume_o} ===
        {e.ns, e.num, e.cancel, e.altisa, e.hyp, e.resume}, e.fix ? "R8" : "R7",
        {tag, " exc fields"},
        {exc_ns_o, exc_num_o, exc_cancel_o, exc_altisa_o, exc_hyp_o, exc_resume_o},
        {e.ns, e.num, e.cancel, e.altisa, e.hyp, e.resume});
    mref = e.addr;  // R10 reference follows each completed packet
    if (idle_after) begin
      @(negedge clk);
      chk(done_o === 1'b0, "R9", {tag, " done is single cycle"}, done_o, 0);
      chk(tgt_addr_o === e.addr, "R9", {tag, " target held"}, tgt_addr_o, e.addr);
    end
  endtask

  task automatic gen_random();
    int k;
    pk_alt  = $urandom % 2;
    pk_alen = 1 + ($urandom % 5);
    for (int i = 0; i < 5; i++) pk_a[i] = 8'($urandom);
    for (int i = 0; i < pk_alen - 1; i++) pk_a[i][7] = 1'b1;
    if (pk_alen < 5) pk_a[pk_alen-1][7] = 1'b0;
    else begin
      k = $urandom % 4;
      case (k)
        0: pk_a[4] = (pk_a[4] & 8'h47) | 8'h08;
        1: pk_a[4] = (pk_a[4] & 8'h4F) | 8'h10;
        2: pk_a[4] = (pk_a[4] & 8'h5F) | 8'h20;
        default: ;
      endcase
    end
    pk_elen = 1 + ($urandom % 3);
    for (int j = 0; j < 3; j++) pk_e[j] = 8'($urandom);
    for (int j = 0; j < pk_elen - 1; j++) pk_e[j][7] = 1'b1;
    if (pk_elen < 3) pk_e[pk_elen-1][7] = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(done_o === 1'b0 && exc_valid_o === 1'b0, "R11", "reset flags", {done_o, exc_valid_o}, 0);
    chk(tgt_addr_o === 32'h0 && state_o === 2'd0, "R11", "reset target/state", tgt_addr_o, 0);

    // R10 load reference, R1 single byte packet
    ref_addr = 32'hA5A5_5A5A; ref_load = 1'b1; @(negedge clk); ref_load = 1'b0;
    mref = 32'hA5A5_5A5A;
    pk_alt = 0; pk_alen = 1; pk_a[0] = 8'h03; cur_state = 2'd0;
    run_pkt("R1 R10 one byte", 0, 0, 1);
    chk(tgt_addr_o === 32'hA5A5_5A04, "R10", "loaded reference fill", tgt_addr_o, 32'hA5A5_5A04);

    // R3 R4 five-byte packets for each state, and an unmatched fifth byte
    pk_alt = 0; pk_alen = 5;
    pk_a[0] = 8'hFF; pk_a[1] = 8'h81; pk_a[2] = 8'hC3; pk_a[3] = 8'h85; pk_a[4] = 8'h08;
    cur_state = 2'd2; run_pkt("R3 word", 0, 0, 1);
    pk_a[4] = 8'h1F; cur_state = 2'd0; run_pkt("R3 half", 0, 0, 1);
    pk_a[4] = 8'h27; cur_state = 2'd0; run_pkt("R3 byte", 0, 0, 1);
    pk_a[4] = 8'h00; cur_state = 2'd1; run_pkt("R3 unmatched keeps", 0, 0, 1);

    // R1 fifth byte with bit 7 set still ends the address
    pk_a[4] = 8'h88; cur_state = 2'd0; run_pkt("R1 cap", 0, 0, 0);
    pk_alen = 1; pk_a[0] = 8'h41; run_pkt("R1 after cap", 0, 0, 1);

    // R5 alternative escape with two exception bytes and the R8 rewrite
    pk_alt = 1; pk_alen = 2; pk_a[0] = 8'h95; pk_a[1] = 8'h4A;
    pk_elen = 2; pk_e[0] = 8'hB3; pk_e[1] = 8'h6D;
    run_pkt("R5 R8 alt escape", 0, 0, 1);
    // R5 single byte: bit 6 is payload, no escape
    pk_alen = 1; pk_a[0] = 8'h47; run_pkt("R5 single byte", 0, 0, 1);

    // R6 original placement: short packet bit 6 ignored, 5-byte escape honoured
    pk_alt = 0; pk_alen = 3; pk_a[0] = 8'h81; pk_a[1] = 8'h82; pk_a[2] = 8'h43;
    run_pkt("R6 short ignored", 0, 0, 0);
    pk_alen = 1; pk_a[0] = 8'h05; run_pkt("R6 next packet", 0, 0, 1);
    pk_alen = 5; pk_a[0] = 8'h81; pk_a[1] = 8'h80; pk_a[2] = 8'h80; pk_a[3] = 8'h80; pk_a[4] = 8'h58;
    pk_elen = 3; pk_e[0] = 8'hFF; pk_e[1] = 8'hA5; pk_e[2] = 8'h7E;
    run_pkt("R6 R7 five-byte escape", 0, 0, 1);

    // R12 mode changes after the first byte are ignored
    pk_alt = 1; pk_alen = 2; pk_a[0] = 8'h81; pk_a[1] = 8'h7F;
    pk_elen = 1; pk_e[0] = 8'h2B;
    run_pkt("R12 mode flip", 1, 0, 1);
    pk_alt = 0; pk_alen = 2; pk_a[0] = 8'h81; pk_a[1] = 8'h7F;
    run_pkt("R12 mode flip orig", 1, 0, 1);

    // R11 reset in the middle of a packet
    put_byte(8'h81, 0, 0); put_byte(8'h83, 0, 0);
    in_valid = 1'b0; rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
    mref = 32'h0;
    chk(done_o === 1'b0 && tgt_addr_o === 32'h0, "R11", "mid-packet reset", tgt_addr_o, 0);
    pk_alt = 0; pk_alen = 1; pk_a[0] = 8'h11; cur_state = 2'd1;
    run_pkt("R11 fresh packet", 0, 0, 1);

    // random traffic
    for (int n = 0; n < 600; n++) begin
      gen_random();
      cur_state = 2'($urandom % 3);
      if ($urandom % 8 == 0) begin
        ref_addr = $urandom; ref_load = 1'b1; in_valid = 1'b0;
        @(negedge clk); ref_load = 1'b0; mref = ref_addr;
      end
      run_pkt("random", ($urandom % 4) == 0, 1, ($urandom % 2) == 0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule